// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeat-Word Serial Pattern Generator

This block produces a serial NRZ test stream for checking digital links. It is built around a shift register of up to 32 stages. In pseudorandom mode it runs as a linear feedback shift register. The sequence length N and a second feedback tap are set at run time. In repeat mode it recirculates a user word of 1 to 32 bits, most significant bit first. One output bit is produced per rising clock edge while the transmit-hold input is low. A high hold input freezes both the stream and the register, so a gapped clock is supported.

A rising edge on the load pin, or on the equivalent control bit, restarts the stream with a fixed latency. Errors can be forced into the stream in two ways: one bit on request, or one bit in every 10^k sent bits for k from 1 to 7. A forced error inverts only the transmitted bit. The register keeps running, so the pattern continues undisturbed afterwards.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rstN` is low and after its release, before any load, `dataOut` is 0.
- R2: The first clock edge at which `loadPin | loadBit` is sampled high after being sampled low counts as edge 1. The register takes its seed at edge 2. Bit N-1 of the seed (the first pattern bit) appears on `dataOut` after edge 3, with `txHold` low.
- R3: At any clock edge where `txHold` is high, `dataOut` keeps its value and the sequence does not advance. The next bit appears at the first edge with `txHold` low.
- R4: In pseudorandom mode (`repMode` = 0) the seed is all ones, whatever `seedWord` holds.
- R5: In pseudorandom mode, with N = `patLen` + 1 and T = `tapSel` (T < N), the output stream o obeys o[j] = o[j-N] XOR (`tapEn` ? o[j-1-T] : 0). The first N bits after a load are 1.
- R6: In repeat mode (`repMode` = 1) the stream is `seedWord`[N-1] down to `seedWord`[0], repeated. `tapSel` and `tapEn` have no effect.
- R7: When `errSingle` is high at an edge with `txHold` low, the bit sent at that edge is inverted. When it arrives during hold, the inversion falls on the first bit sent afterwards.
- R8: With `errRate` = k (1 to 7), the bits with zero-based index i after a load, where i mod 10^k = 10^k - 1, are inverted. `errRate` = 0 injects nothing.
- R9: After an injected error, the following bits equal the error-free sequence.
- R10: A load input held high triggers only one reload. `loadBit` acts exactly like `loadPin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txHold | input | 1 | High: hold the current bit and freeze the sequence |
| loadPin | input | 1 | Load request, rising edge restarts the pattern |
| loadBit | input | 1 | Control-register load request, ORed with `loadPin` |
| repMode | input | 1 | 1 = repeat word, 0 = pseudorandom |
| patLen | input | 5 | Pattern length minus one (N-1) |
| tapSel | input | 5 | Second feedback stage |
| tapEn | input | 1 | Enables the second tap (pseudorandom mode only) |
| seedWord | input | 32 | Repeat word |
| errRate | input | 3 | 0 = off, k = one error per 10^k bits |
| errSingle | input | 1 | One-cycle request for a single bit error |
| dataOut | output | 1 | Serial NRZ data |

## Verification
A rising load request is first registered and then edge-detected, so the seed enters the register on the second edge. The first bit is visible on the third edge. The bench therefore lets three falling edges pass after raising the request, then compares one bit per falling edge against a model built from the R5 and R6 recurrences. Hold and single-error inputs are changed at a falling edge and take effect at the very next rising edge. Rate errors are predicted by counting bit indices from the third edge.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  typedef struct packed {
    logic load;     // copy seed into the shift register
    logic advance;  // send one bit and step the sequence
    logic flip;     // invert the bit sent this cycle
  } genStrobes_t;
endpackage

// File: rtl/prbs_gen_ctrl.sv
module prbs_gen_ctrl #(
  parameter int NUM_DECADES = 7,
  localparam int RATE_W = $clog2(NUM_DECADES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic txHold,
  input  logic loadReq,
  input  logic [RATE_W-1:0] errRate,
  input  logic errSingle,
  output prbs_gen_pkg::genStrobes_t strobes
);
  logic loadSeen, loadPrev, singlePend, rateHit;
  logic [3:0] digit [NUM_DECADES];
  logic [NUM_DECADES:0] carry;
  logic [NUM_DECADES:0] nineUpTo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadSeen <= 1'b0;
      loadPrev <= 1'b0;
      singlePend <= 1'b0;
    end else begin
      loadSeen <= loadReq;
      loadPrev <= loadSeen;
      if (strobes.advance) singlePend <= 1'b0;
      else if (errSingle) singlePend <= 1'b1;
    end
  end

  assign carry[0] = strobes.advance;
  assign nineUpTo[0] = 1'b1;

  for (genvar d = 0; d < NUM_DECADES; d++) begin : g_decade
    assign carry[d+1] = carry[d] & (digit[d] == 4'd9);
    assign nineUpTo[d+1] = nineUpTo[d] & (digit[d] == 4'd9);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) digit[d] <= 4'd0;
      else if (strobes.load) digit[d] <= 4'd0;
      else if (carry[d]) digit[d] <= (digit[d] == 4'd9) ? 4'd0 : digit[d] + 4'd1;
    end
    a_r8_digit_range: assert property (@(posedge clk) disable iff (!rstN)
      digit[d] <= 4'd9);
  end

  assign rateHit = (errRate != '0) && (int'(errRate) <= NUM_DECADES) && nineUpTo[errRate];

  always_comb begin
    strobes.load = loadSeen & ~loadPrev;
    strobes.advance = ~txHold;
    strobes.flip = ~txHold & (singlePend | errSingle | rateHit);
  end

  a_r10_load_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !strobes.load);
  a_r7_single_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (singlePend && strobes.advance) |=> !singlePend);
  a_r9_flip_on_sent_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flip |-> strobes.advance);
endmodule

// File: rtl/prbs_gen_datapath.sv
module prbs_gen_datapath #(
  parameter int WIDTH = 32,
  localparam int LEN_W = $clog2(WIDTH)
) (
  input  logic clk,
  input  logic rstN,
  input  prbs_gen_pkg::genStrobes_t strobes,
  input  logic repMode,
  input  logic [LEN_W-1:0] patLen,
  input  logic [LEN_W-1:0] tapSel,
  input  logic tapEn,
  input  logic [WIDTH-1:0] seedWord,
  output logic dataOut
);
  logic [WIDTH-1:0] shiftReg;
  logic headBit, feedback;

  assign headBit = shiftReg[patLen];
  assign feedback = headBit ^ (tapEn & ~repMode & shiftReg[tapSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataOut <= 1'b0;
    end else begin
      if (strobes.load) shiftReg <= repMode ? seedWord : '1;
      else if (strobes.advance) shiftReg <= {shiftReg[WIDTH-2:0], feedback};
      if (strobes.advance) dataOut <= headBit ^ strobes.flip;
    end
  end

  a_r3_hold_keeps_bit: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(dataOut));
  a_r3_hold_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.load) |=> $stable(shiftReg));
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
  parameter int WIDTH = 32,
  parameter int NUM_DECADES = 7,
  localparam int LEN_W = $clog2(WIDTH),
  localparam int RATE_W = $clog2(NUM_DECADES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic txHold,
  input  logic loadPin,
  input  logic loadBit,
  input  logic repMode,
  input  logic [LEN_W-1:0] patLen,
  input  logic [LEN_W-1:0] tapSel,
  input  logic tapEn,
  input  logic [WIDTH-1:0] seedWord,
  input  logic [RATE_W-1:0] errRate,
  input  logic errSingle,
  output logic dataOut
);
  prbs_gen_pkg::genStrobes_t strobes;

  prbs_gen_ctrl #(.NUM_DECADES(NUM_DECADES)) i_ctrl (
    .clk(clk), .rstN(rstN), .txHold(txHold), .loadReq(loadPin | loadBit),
    .errRate(errRate), .errSingle(errSingle), .strobes(strobes)
  );

  prbs_gen_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .repMode(repMode),
    .patLen(patLen), .tapSel(tapSel), .tapEn(tapEn), .seedWord(seedWord),
    .dataOut(dataOut)
  );
endmodule

// File: tb/test_prbs_pattern_gen.sv
module test_prbs_pattern_gen;
  logic clk = 1'b0, rstN = 1'b0, txHold = 1'b0, loadPin = 1'b0, loadBit = 1'b0;
  logic repMode = 1'b1, tapEn = 1'b0, errSingle = 1'b0;
  logic [4:0] patLen = 5'd7, tapSel = 5'd0;
  logic [31:0] seedWord = '0;
  logic [2:0] errRate = 3'd0;
  logic dataOut;
  int checks = 0, errors = 0;
  bit expBits [256];

  // fields: repMode, patLen (N-1), tapSel, tapEn, seedWord
  localparam logic [43:0] VECS [7] = '{
    {1'b0, 5'd6,  5'd5,  1'b1, 32'h1234_5678},
    {1'b0, 5'd6,  5'd5,  1'b1, 32'h0000_0000},
    {1'b0, 5'd8,  5'd4,  1'b1, 32'hFFFF_0000},
    {1'b0, 5'd14, 5'd13, 1'b1, 32'h0F0F_0F0F},
    {1'b1, 5'd7,  5'd3,  1'b1, 32'h0000_00A5},
    {1'b1, 5'd0,  5'd0,  1'b0, 32'h0000_0001},
    {1'b1, 5'd31, 5'd9,  1'b1, 32'hDEAD_BEEF}
  };

  always #10 clk = ~clk;

  prbs_pattern_gen i_prbs_pattern_gen (
    .clk(clk), .rstN(rstN), .txHold(txHold), .loadPin(loadPin), .loadBit(loadBit),
    .repMode(repMode), .patLen(patLen), .tapSel(tapSel), .tapEn(tapEn),
    .seedWord(seedWord), .errRate(errRate), .errSingle(errSingle), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void buildExp(input bit rep, input int n, input int tap,
                                   input bit en, input logic [31:0] seed);
    for (int j = 0; j < 256; j++) begin
      if (rep) expBits[j] = seed[n - 1 - (j % n)];
      else if (j < n) expBits[j] = 1'b1;
      else expBits[j] = expBits[j - n] ^ (en & expBits[j - 1 - tap]);
    end
  endfunction

  // raise the load pin, leave it after one edge; returns at the falling edge after edge 3
  task automatic doLoad();
    @(negedge clk) loadPin = 1'b1;
    @(negedge clk) loadPin = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input bit rep, input int n, input int tap, input bit en,
                       input logic [31:0] seed);
    @(negedge clk);
    repMode = rep; patLen = 5'(n - 1); tapSel = 5'(tap); tapEn = en; seedWord = seed;
    buildExp(rep, n, tap, en, seed);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog actual=0 expected=1");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(dataOut == 1'b0, "R1 in reset", int'(dataOut), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(dataOut == 1'b0, "R1 after release", int'(dataOut), 0);

    // vector table walk: R4 R5 (pseudorandom) and R6 (repeat), errRate 0 (R8)
    foreach (VECS[v]) begin
      logic [43:0] e;
      e = VECS[v];
      setup(e[43], int'(e[42:38]) + 1, int'(e[37:33]), e[32], e[31:0]);
      doLoad();
      bad = 0;
      for (int i = 0; i < 80; i++) begin
        if (dataOut !== expBits[i]) bad++;
        @(negedge clk);
      end
      check(bad == 0, e[43] ? "R6 R8 repeat vector" : "R4 R5 R8 prbs vector", bad, 0);
    end

    // R2 load latency: quiet word, then a word with only its first bit set
    setup(1'b1, 8, 0, 1'b0, 32'h0000_0000);
    doLoad();
    repeat (10) @(negedge clk);
    seedWord = 32'h0000_0080;
    loadPin = 1'b1;
    @(negedge clk) loadPin = 1'b0;
    check(dataOut == 1'b0, "R2 after edge 1", int'(dataOut), 0);
    @(negedge clk);
    check(dataOut == 1'b0, "R2 after edge 2", int'(dataOut), 0);
    @(negedge clk);
    check(dataOut == 1'b1, "R2 after edge 3", int'(dataOut), 1);
    @(negedge clk);
    check(dataOut == 1'b0, "R2 after edge 4", int'(dataOut), 0);

    // R3 hold: stream A5, hold for three edges after bit 1
    setup(1'b1, 8, 0, 1'b0, 32'h0000_00A5);
    doLoad();
    @(negedge clk);
    txHold = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (dataOut !== expBits[1]) bad++;
    end
    check(bad == 0, "R3 bit held", bad, 0);
    txHold = 1'b0;
    bad = 0;
    for (int i = 2; i < 20; i++) begin
      @(negedge clk);
      if (dataOut !== expBits[i]) bad++;
    end
    check(bad == 0, "R3 resumes in order", bad, 0);

    // R7 single error at bit 3, R9 stream continues
    setup(1'b1, 8, 0, 1'b0, 32'h0000_00A5);
    doLoad();
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      if (i == 3) check(dataOut == !expBits[3], "R7 single bit inverted", int'(dataOut), int'(!expBits[3]));
      else if (dataOut !== expBits[i]) bad++;
      errSingle = (i == 2);
      @(negedge clk);
    end
    errSingle = 1'b0;
    check(bad == 0, "R9 after single error", bad, 0);

    // R7 request during hold lands on the first bit sent after release
    setup(1'b1, 8, 0, 1'b0, 32'h0000_00A5);
    doLoad();
    txHold = 1'b1;
    errSingle = 1'b1;
    @(negedge clk) errSingle = 1'b0;
    @(negedge clk) txHold = 1'b0;
    @(negedge clk);
    check(dataOut == !expBits[1], "R7 deferred by hold", int'(dataOut), int'(!expBits[1]));
    @(negedge clk);
    check(dataOut == expBits[2], "R9 after deferred error", int'(dataOut), int'(expBits[2]));

    // R8 rate 10^-1 and 10^-2 on a PRBS-7 stream
    for (int k = 1; k <= 2; k++) begin
      int period;
      period = (k == 1) ? 10 : 100;
      setup(1'b0, 7, 5, 1'b1, 32'h0);
      errRate = 3'(k);
      doLoad();
      bad = 0;
      for (int i = 0; i < 210; i++) begin
        if (dataOut !== (expBits[i] ^ ((i % period) == period - 1))) bad++;
        @(negedge clk);
      end
      check(bad == 0, k == 1 ? "R8 R9 rate 1" : "R8 R9 rate 2", bad, 0);
    end
    errRate = 3'd0;

    // R10 loadBit held high: one reload, PRBS-7 runs on without restart
    setup(1'b0, 7, 5, 1'b1, 32'h0);
    @(negedge clk) loadBit = 1'b1;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      if (dataOut !== expBits[i]) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10 level load no reload", bad, 0);
    loadBit = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule